// File: doc/BRIEF.md
# Multicycle 32-bit RISC Processor Core

This block is a small 32-bit processor core. Each instruction is broken into a short run of one-clock steps: fetch, decode with operand read, execute, memory access and write-back. Only the steps an instruction class needs are used, so instructions take different numbers of cycles. A single word-addressed memory array holds both the program and its data. One ALU does every addition, subtraction and logic operation, including the PC increment and the branch target. Holding registers keep values from one step to the next: the instruction word, the memory data word, the two operands and the ALU result. A state machine decodes the current step and the opcode into multiplexer selects and register enables.

The supported instructions are word load, word store, register-register add/sub/and/or/set-less-than, branch-if-equal and absolute jump. Before reset is released, the surrounding logic fills the memory through a load port. After that, it can read any register and any memory word through two read-only inspection ports. A one-cycle `step_done` pulse marks every return to the fetch step, which is the point where the architectural state of the last instruction can be inspected.

Top module: `mc_cpu`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `pc_out` is 0, the core is in the fetch step and `step_done` is low.
- R2: The fetch step loads the instruction register from the memory word at PC and advances PC by 4. No other step loads the instruction register.
- R3: Counting the fetch step, the number of clocks per instruction is 3 for branch-if-equal (opcode 0x04) and jump (0x02), 4 for register-register (0x00) and store (0x2B), 5 for load (0x23), and 2 for any other opcode. `step_done` is high for exactly the one cycle that follows the last step.
- R4: A register-register instruction writes rs op rt into rd. The ALU operation comes from bits [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, and 0x2A signed set-less-than, which gives 1 or 0.
- R5: A load writes into rt the memory word at rs plus the sign-extended bits [15:0]. The word index is taken from byte-address bits [MEM_AW+1:2].
- R6: A store writes rt into the memory word at rs plus the sign-extended bits [15:0].
- R7: A branch-if-equal sets PC to (address of the branch + 4) + (sign-extended bits [15:0] << 2) when rs equals rt. Otherwise PC is the address of the branch + 4.
- R8: A jump sets PC to {bits [31:28] of (address of the jump + 4), bits [25:0], 2'b00}.
- R9: Register 0 always reads as zero, including after an instruction that names it as destination.
- R10: An unsupported opcode changes no register and no memory word. Its only effect is PC + 4.
- R11: Instruction fields are rs = bits [25:21], rt = bits [20:16], rd = bits [15:11] and opcode = bits [31:26]. One memory serves instruction fetch, loads, stores and the load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we | input | 1 | Write enable of the memory load port |
| load_addr | input | MEM_AW | Word index written by the load port |
| load_data | input | 32 | Word written by the load port |
| peek_addr | input | MEM_AW | Word index of the memory inspection port |
| peek_data | output | 32 | Memory word at `peek_addr` |
| dbg_rsel | input | 5 | Register number of the register inspection port |
| dbg_rdata | output | 32 | Value of register `dbg_rsel` |
| pc_out | output | 32 | Current program counter |
| step_done | output | 1 | One-cycle pulse on each return to the fetch step |

## Verification
The program run on the core mixes all five register-register operations on a positive and a negative operand, so that signed and unsigned comparison give different results. It also includes an instruction that targets register 0. The loads and stores use different addresses, and a load reads back a word just stored, which separates the load and store address paths. The program contains a branch that is not taken, two forward branches that are taken, a skipped instruction, an unsupported opcode and a jump onto itself. Any step taken too many or too few shows up as a mismatch in the per-clock `step_done` comparison or as a nonzero value in a register that should have been skipped.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_EXEC_R, S_EXEC_ADDR, S_EXEC_BR,
        S_EXEC_J, S_WB_R, S_MEM_RD, S_MEM_WR, S_WB_LD
    } state_t;

    typedef enum logic [1:0] {BSEL_REG, BSEL_FOUR, BSEL_IMM, BSEL_IMM_SH} bsel_t;
    typedef enum logic [1:0] {AOP_ADD, AOP_SUB, AOP_FUNCT} aop_t;
    typedef enum logic [1:0] {PSEL_ALU, PSEL_TGT, PSEL_JMP} psel_t;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        state_t next;
        logic   a_from_pc;
        bsel_t  bsel;
        aop_t   aop;
        logic   ir_we;
        logic   pc_we;
        logic   pc_cond;
        psel_t  psel;
        logic   ab_we;
        logic   alo_we;
        logic   mdr_we;
        logic   mem_we;
        logic   addr_alo;
        logic   rf_we;
        logic   rf_dst_rd;
        logic   rf_from_mdr;
    } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aop_t         op,
    input  logic [5:0]   funct,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        y = '0;
        unique case (op)
            AOP_ADD: y = a + b;
            AOP_SUB: y = a - b;
            AOP_FUNCT: begin
                case (funct)
                    FN_ADD:  y = a + b;
                    FN_SUB:  y = a - b;
                    FN_AND:  y = a & b;
                    FN_OR:   y = a | b;
                    FN_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
                    default: y = '0;
                endcase
            end
            default: y = '0;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rs_sel,
    input  logic [AW-1:0] rt_sel,
    input  logic [AW-1:0] dbg_sel,
    output logic [W-1:0]  rs_data,
    output logic [W-1:0]  rt_data,
    output logic [W-1:0]  dbg_data,
    input  logic          we,
    input  logic [AW-1:0] wsel,
    input  logic [W-1:0]  wdata
);
    logic [W-1:0] regs_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we && (wsel != '0)) begin
            regs_q[wsel] <= wdata;
        end
    end

    assign rs_data  = (rs_sel  == '0) ? '0 : regs_q[rs_sel];
    assign rt_data  = (rt_sel  == '0) ? '0 : regs_q[rt_sel];
    assign dbg_data = (dbg_sel == '0) ? '0 : regs_q[dbg_sel];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  state_t     state,
    input  logic [5:0] opcode,
    output ctrl_t      ctl
);
    always_comb begin
        ctl      = '0;
        ctl.next = S_FETCH;
        case (state)
            S_FETCH: begin
                ctl.a_from_pc = 1'b1;
                ctl.bsel      = BSEL_FOUR;
                ctl.aop       = AOP_ADD;
                ctl.ir_we     = 1'b1;
                ctl.pc_we     = 1'b1;
                ctl.psel      = PSEL_ALU;
                ctl.next      = S_DECODE;
            end
            S_DECODE: begin
                ctl.ab_we     = 1'b1;
                ctl.a_from_pc = 1'b1;
                ctl.bsel      = BSEL_IMM_SH;
                ctl.aop       = AOP_ADD;
                ctl.alo_we    = 1'b1;
                case (opcode)
                    OP_RTYPE:          ctl.next = S_EXEC_R;
                    OP_LOAD, OP_STORE: ctl.next = S_EXEC_ADDR;
                    OP_BEQ:            ctl.next = S_EXEC_BR;
                    OP_JUMP:           ctl.next = S_EXEC_J;
                    default:           ctl.next = S_FETCH;
                endcase
            end
            S_EXEC_R: begin
                ctl.bsel   = BSEL_REG;
                ctl.aop    = AOP_FUNCT;
                ctl.alo_we = 1'b1;
                ctl.next   = S_WB_R;
            end
            S_EXEC_ADDR: begin
                ctl.bsel   = BSEL_IMM;
                ctl.aop    = AOP_ADD;
                ctl.alo_we = 1'b1;
                ctl.next   = (opcode == OP_LOAD) ? S_MEM_RD : S_MEM_WR;
            end
            S_EXEC_BR: begin
                ctl.bsel    = BSEL_REG;
                ctl.aop     = AOP_SUB;
                ctl.pc_cond = 1'b1;
                ctl.psel    = PSEL_TGT;
            end
            S_EXEC_J: begin
                ctl.pc_we = 1'b1;
                ctl.psel  = PSEL_JMP;
            end
            S_WB_R: begin
                ctl.rf_we     = 1'b1;
                ctl.rf_dst_rd = 1'b1;
            end
            S_MEM_RD: begin
                ctl.addr_alo = 1'b1;
                ctl.mdr_we   = 1'b1;
                ctl.next     = S_WB_LD;
            end
            S_MEM_WR: begin
                ctl.addr_alo = 1'b1;
                ctl.mem_we   = 1'b1;
            end
            S_WB_LD: begin
                ctl.rf_we       = 1'b1;
                ctl.rf_from_mdr = 1'b1;
            end
            default: ctl.next = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
    import mc_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [31:0]       load_data,
    input  logic [MEM_AW-1:0] peek_addr,
    output logic [31:0]       peek_data,
    input  logic [4:0]        dbg_rsel,
    output logic [31:0]       dbg_rdata,
    output logic [31:0]       pc_out,
    output logic              step_done
);
    localparam int MEM_WORDS = 1 << MEM_AW;

    typedef struct packed {
        state_t      state;
        logic [31:0] pc;
        logic [31:0] ir;
        logic [31:0] mdr;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] alo;
        logic        done;
    } dp_t;

    dp_t         r_q, r_d;
    ctrl_t       ctl;
    logic [31:0] mem_q [MEM_WORDS];
    logic [31:0] sext, alu_a, alu_b, alu_y, mem_rdata, rs_data, rt_data, rf_wdata;
    logic        alu_zero;
    logic [MEM_AW-1:0] mem_idx;
    logic [4:0]  rf_wsel;

    mc_ctrl u_ctrl (
        .state  (r_q.state),
        .opcode (r_q.ir[31:26]),
        .ctl    (ctl)
    );

    mc_alu #(.W(32)) u_alu (
        .a     (alu_a),
        .b     (alu_b),
        .op    (ctl.aop),
        .funct (r_q.ir[5:0]),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    mc_regfile #(.W(32), .NREGS(32)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rs_sel   (r_q.ir[25:21]),
        .rt_sel   (r_q.ir[20:16]),
        .dbg_sel  (dbg_rsel),
        .rs_data  (rs_data),
        .rt_data  (rt_data),
        .dbg_data (dbg_rdata),
        .we       (ctl.rf_we),
        .wsel     (rf_wsel),
        .wdata    (rf_wdata)
    );

    assign sext      = {{16{r_q.ir[15]}}, r_q.ir[15:0]};
    assign mem_idx   = ctl.addr_alo ? r_q.alo[MEM_AW+1:2] : r_q.pc[MEM_AW+1:2];
    assign mem_rdata = mem_q[mem_idx];
    assign rf_wsel   = ctl.rf_dst_rd ? r_q.ir[15:11] : r_q.ir[20:16];
    assign rf_wdata  = ctl.rf_from_mdr ? r_q.mdr : r_q.alo;

    always_comb begin
        alu_a = ctl.a_from_pc ? r_q.pc : r_q.a;
        case (ctl.bsel)
            BSEL_REG:    alu_b = r_q.b;
            BSEL_FOUR:   alu_b = 32'd4;
            BSEL_IMM:    alu_b = sext;
            BSEL_IMM_SH: alu_b = {sext[29:0], 2'b00};
            default:     alu_b = r_q.b;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (ctl.ir_we)  r_d.ir  = mem_rdata;
        if (ctl.mdr_we) r_d.mdr = mem_rdata;
        if (ctl.ab_we) begin
            r_d.a = rs_data;
            r_d.b = rt_data;
        end
        if (ctl.alo_we) r_d.alo = alu_y;
        if (ctl.pc_we || (ctl.pc_cond && alu_zero)) begin
            case (ctl.psel)
                PSEL_ALU: r_d.pc = alu_y;
                PSEL_TGT: r_d.pc = r_q.alo;
                PSEL_JMP: r_d.pc = {r_q.pc[31:28], r_q.ir[25:0], 2'b00};
                default:  r_d.pc = alu_y;
            endcase
        end
        r_d.state = ctl.next;
        r_d.done  = (ctl.next == S_FETCH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_FETCH;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (load_we)          mem_q[load_addr] <= load_data;
        else if (ctl.mem_we)  mem_q[mem_idx]   <= r_q.b;
    end

    assign peek_data = mem_q[peek_addr];
    assign pc_out    = r_q.pc;
    assign step_done = r_q.done;
endmodule

// File: rtl/mc_cpu_chk.sv
module mc_cpu_chk
    import mc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input state_t      state,
    input logic [31:0] pc,
    input logic [31:0] ir,
    input logic        step_done,
    input logic [4:0]  dbg_rsel,
    input logic [31:0] dbg_rdata
);
    logic known_op;
    assign known_op = (ir[31:26] == OP_RTYPE) || (ir[31:26] == OP_LOAD) ||
                      (ir[31:26] == OP_STORE) || (ir[31:26] == OP_BEQ) ||
                      (ir[31:26] == OP_JUMP);

    a_r2_pc_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |=> (pc == $past(pc) + 32'd4));

    a_r2_ir_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_FETCH) |=> $stable(ir));

    a_r3_done_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> (state == S_FETCH));

    a_r3_short_class: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC_BR || state == S_EXEC_J) |=> (state == S_FETCH && step_done));

    a_r3_fetch_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |=> (state == S_DECODE && !step_done));

    a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rsel == 5'd0) |-> (dbg_rdata == 32'd0));

    a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && !known_op) |=> (state == S_FETCH));
endmodule

bind mc_cpu mc_cpu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (r_q.state),
    .pc        (r_q.pc),
    .ir        (r_q.ir),
    .step_done (step_done),
    .dbg_rsel  (dbg_rsel),
    .dbg_rdata (dbg_rdata)
);

// File: tb/mc_cpu_tb.sv
`timescale 1ns/1ps
module mc_cpu_tb;
    localparam int MEM_AW = 8;
    localparam int NW     = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_we = 1'b0;
    logic [MEM_AW-1:0] load_addr = '0;
    logic [31:0]       load_data = '0;
    logic [MEM_AW-1:0] peek_addr = '0;
    logic [31:0]       peek_data;
    logic [4:0]        dbg_rsel = '0;
    logic [31:0]       dbg_rdata;
    logic [31:0]       pc_out;
    logic              step_done;

    int checks = 0;
    int failures = 0;

    logic [31:0] mreg [32];
    logic [31:0] mmem [NW];
    logic [31:0] mpc;

    always #2 clk = ~clk;

    mc_cpu #(.MEM_AW(MEM_AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .dbg_rsel(dbg_rsel), .dbg_rdata(dbg_rdata),
        .pc_out(pc_out), .step_done(step_done)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] rd, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // Reference model: executes one instruction, returns its clock count and what to inspect
    task automatic model_step(output int cyc, output int dreg, output int dmem);
        logic [31:0] ins, npc, sx, res, addr;
        ins  = mmem[mpc[MEM_AW+1:2]];
        npc  = mpc + 32'd4;
        sx   = {{16{ins[15]}}, ins[15:0]};
        dreg = -1;
        dmem = -1;
        case (ins[31:26])
            6'h00: begin
                case (ins[5:0])
                    6'h20: res = mreg[ins[25:21]] + mreg[ins[20:16]];
                    6'h22: res = mreg[ins[25:21]] - mreg[ins[20:16]];
                    6'h24: res = mreg[ins[25:21]] & mreg[ins[20:16]];
                    6'h25: res = mreg[ins[25:21]] | mreg[ins[20:16]];
                    6'h2A: res = ($signed(mreg[ins[25:21]]) < $signed(mreg[ins[20:16]])) ? 32'd1 : 32'd0;
                    default: res = 32'd0;
                endcase
                if (ins[15:11] != 5'd0) mreg[ins[15:11]] = res;
                dreg = int'(ins[15:11]);
                cyc = 4;
            end
            6'h23: begin
                addr = mreg[ins[25:21]] + sx;
                if (ins[20:16] != 5'd0) mreg[ins[20:16]] = mmem[addr[MEM_AW+1:2]];
                dreg = int'(ins[20:16]);
                cyc = 5;
            end
            6'h2B: begin
                addr = mreg[ins[25:21]] + sx;
                mmem[addr[MEM_AW+1:2]] = mreg[ins[20:16]];
                dmem = int'(addr[MEM_AW+1:2]);
                cyc = 4;
            end
            6'h04: begin
                if (mreg[ins[25:21]] == mreg[ins[20:16]]) npc = npc + {sx[29:0], 2'b00};
                cyc = 3;
            end
            6'h02: begin
                npc = {npc[31:28], ins[25:0], 2'b00};
                cyc = 3;
            end
            default: cyc = 2;
        endcase
        mpc = npc;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) mmem[i] = 32'd0;
        for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
        mpc = 32'd0;
        mmem[64] = 32'd7;
        mmem[65] = 32'hFFFF_FFFD;
        mmem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
        mmem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
        mmem[2]  = enc_r(5'd3, 5'd1, 5'd2, 6'h20);
        mmem[3]  = enc_r(5'd4, 5'd1, 5'd2, 6'h22);
        mmem[4]  = enc_r(5'd5, 5'd1, 5'd2, 6'h24);
        mmem[5]  = enc_r(5'd6, 5'd1, 5'd2, 6'h25);
        mmem[6]  = enc_r(5'd7, 5'd2, 5'd1, 6'h2A);
        mmem[7]  = enc_r(5'd8, 5'd1, 5'd2, 6'h2A);
        mmem[8]  = enc_r(5'd0, 5'd1, 5'd1, 6'h20);
        mmem[9]  = enc_i(6'h2B, 5'd0, 5'd4, 16'h0108);
        mmem[10] = enc_i(6'h23, 5'd0, 5'd9, 16'h0108);
        mmem[11] = enc_i(6'h04, 5'd1, 5'd2, 16'd5);
        mmem[12] = enc_i(6'h04, 5'd3, 5'd3, 16'd2);
        mmem[13] = enc_r(5'd10, 5'd1, 5'd1, 6'h20);
        mmem[14] = enc_r(5'd10, 5'd1, 5'd1, 6'h20);
        mmem[15] = {6'h3F, 5'd1, 5'd11, 16'h0004};
        mmem[16] = enc_i(6'h04, 5'd0, 5'd0, 16'd1);
        mmem[17] = enc_r(5'd10, 5'd1, 5'd1, 6'h20);
        mmem[18] = {6'h02, 26'd20};
        mmem[19] = enc_r(5'd10, 5'd1, 5'd1, 6'h20);
        mmem[20] = enc_i(6'h2B, 5'd0, 5'd1, 16'h010C);
        mmem[21] = {6'h02, 26'd21};

        // R11: fill the single memory through the load port during reset
        for (int i = 0; i < NW; i++) begin
            @(negedge clk);
            load_we   = 1'b1;
            load_addr = MEM_AW'(i);
            load_data = mmem[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        check("R1 pc in reset", pc_out, 32'd0);
        check("R1 step_done in reset", {31'd0, step_done}, 32'd0);
        rst_n = 1'b1;
        #0.5;
        check("R1 pc after reset", pc_out, 32'd0);
        check("R1 step_done after reset", {31'd0, step_done}, 32'd0);

        for (int n = 0; n < 24; n++) begin
            int cyc, dreg, dmem;
            model_step(cyc, dreg, dmem);
            for (int c = 1; c <= cyc; c++) begin
                @(posedge clk);
                @(negedge clk);
                // R3: step_done only in the cycle after the last step
                check($sformatf("R3 step_done instr %0d cycle %0d", n, c),
                      {31'd0, step_done}, {31'd0, (c == cyc)});
            end
            // R2 R7 R8 R10: program counter after each instruction
            check($sformatf("R2/R7/R8 pc after instr %0d", n), pc_out, mpc);
            if (dreg >= 0) begin
                dbg_rsel = 5'(dreg);
                #0.5;
                // R4 R5 R9: destination register value
                check($sformatf("R4/R5/R9 reg %0d after instr %0d", dreg, n), dbg_rdata, mreg[dreg]);
            end
            if (dmem >= 0) begin
                peek_addr = MEM_AW'(dmem);
                #0.5;
                check($sformatf("R6 mem word %0d after instr %0d", dmem, n), peek_data, mmem[dmem]);
            end
        end

        // R9 R10: final sweep; skipped instructions and the bad opcode left no trace
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            dbg_rsel = 5'(i);
            #0.5;
            check($sformatf("R9/R10 final reg %0d", i), dbg_rdata, mreg[i]);
        end
        for (int i = 64; i < 68; i++) begin
            @(negedge clk);
            peek_addr = MEM_AW'(i);
            #0.5;
            check($sformatf("R6/R11 final mem word %0d", i), peek_data, mmem[i]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule